// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing for a raster display. Software sets every edge position through a small register port. Two counters track the current pixel and line. From those counters the block derives an active-region flag, a blanking output, a horizontal sync, a vertical sync and the current x/y coordinates. All of these outputs leave the block from a single register stage, so they change on the same clock edge.

Each axis has three timing words. Every word holds two 12-bit positions, each stored as the intended value minus one: one in bits [11:0] and one in bits [27:16]. A key register guards the configuration and timing words. Software writes the key, clears the generator enable, reprograms the timing, sets the enable again and then writes any other value to relock. Timing words written while the generator runs are held back until the frame boundary, so no frame is ever drawn with a mix of old and new timing.

Top module: `raster_timing_top`

## Requirements
- R1: Writes to the configuration word (address 1) and the timing words (addresses 2 to 7) take effect only while the port is unlocked. Writing 32'h0000_4758 to address 0 unlocks the port. Writing any other value to address 0 locks it. Reset leaves the port locked. Address 0 reads back 1 when unlocked and 0 when locked.
- R2: The timing word addresses are: 2 horizontal active/total, 3 horizontal blank start/end, 4 horizontal sync start/end, 5 vertical active/total, 6 vertical blank start/end, 7 vertical sync start/end. Each word keeps bits [11:0] (the first value) and bits [27:16] (the second value), and all other bits read as zero. `reg_rdata` shows the word at `reg_addr` one clock after the address is presented, and it shows newly written values at once.
- R3: The configuration word uses bit 0 as the generator enable, bit 1 to invert horizontal sync and bit 2 to invert vertical sync. While the enable is clear, both counters stay at zero, `blank_o` is 1, `active_o` is 0, and each sync output sits at its inactive level (0, or 1 when inverted).
- R4: When the enable is set at clock edge E, the outputs report position (0,0) after edge E+1 and then move forward one pixel per clock. `pix_x`, `pix_y`, `active_o`, `blank_o`, `hsync_o` and `vsync_o` always describe the same pixel.
- R5: `pix_x` runs from 0 to the horizontal total minus 1 and then returns to 0. `pix_y` goes up by one at each line wrap and returns to 0 after the vertical total minus 1.
- R6: `blank_o` is 1 when x lies in [blank start, blank end) horizontally, or when y lies in [blank start, blank end) vertically.
- R7: `hsync_o` is active for x in [sync start, sync end). `vsync_o` is active for y in [sync start, sync end).
- R8: `active_o` is 1 only when x is below the horizontal active size and y is below the vertical active size.
- R9: The configuration bits 1 and 2 each invert their sync output, both inside and outside the sync window.
- R10: A timing word written while the generator is enabled changes the outputs only from position (0,0) of the next frame onward. The current frame keeps the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| pix_x | output | 12 | Current horizontal position |
| pix_y | output | 12 | Current vertical position |
| active_o | output | 1 | Pixel lies in the visible area |
| blank_o | output | 1 | Blanking interval |
| hsync_o | output | 1 | Horizontal sync, after polarity |
| vsync_o | output | 1 | Vertical sync, after polarity |

## Verification
The counter assertions assume that each total is at least as large as every window bound programmed for that axis. They also assume that software never writes a total that takes effect in the middle of a frame; the frame-boundary loading guarantees this unless the generator is disabled. The assertion on blanking while disabled relies on the enable being the only source of forced blanking. The stimulus always programs totals that cover every window, changes a total only while the generator is disabled, and issues exactly one register write per clock.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int          AW         = 3;
  localparam int          DW         = 32;
  localparam int          NTIM       = 6;
  localparam int          HI_LSB     = 16;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_4758;

  localparam logic [AW-1:0] ADR_KEY  = 3'd0;
  localparam logic [AW-1:0] ADR_CFG  = 3'd1;
  localparam logic [AW-1:0] ADR_TIM0 = 3'd2;

  localparam int CFG_EN   = 0;
  localparam int CFG_HPOL = 1;
  localparam int CFG_VPOL = 2;

  // index of each word inside one axis group
  localparam int W_ACT = 0;
  localparam int W_BLK = 1;
  localparam int W_SYN = 2;
  localparam int WPA   = 3;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic                     frame_end,
  output logic [DW-1:0]            rdata,
  output logic                     en,
  output logic                     hpol,
  output logic                     vpol,
  output logic [NTIM-1:0][CW-1:0]  live_lo,
  output logic [NTIM-1:0][CW-1:0]  live_hi
);
  logic                    unlocked;
  logic                    wr_ok;
  logic [NTIM-1:0][CW-1:0] pend_lo;
  logic [NTIM-1:0][CW-1:0] pend_hi;
  logic                    unused_wbits;

  assign wr_ok        = wr && unlocked;
  assign unused_wbits = ^{wdata[HI_LSB-1:CW], wdata[DW-1:HI_LSB+CW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
    end else if (wr && addr == ADR_KEY) begin
      unlocked <= (wdata == UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      hpol <= 1'b0;
      vpol <= 1'b0;
    end else if (wr_ok && addr == ADR_CFG) begin
      en   <= wdata[CFG_EN];
      hpol <= wdata[CFG_HPOL];
      vpol <= wdata[CFG_VPOL];
    end
  end

  // pending copies: software view
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_lo <= '0;
      pend_hi <= '0;
    end else if (wr_ok) begin
      for (int i = 0; i < NTIM; i++) begin
        if (addr == AW'(i + 2)) begin
          pend_lo[i] <= wdata[CW-1:0];
          pend_hi[i] <= wdata[HI_LSB +: CW];
        end
      end
    end
  end

  // live copies: loaded while idle or at the last pixel of a frame
  always_ff @(posedge clk) begin
    if (rst) begin
      live_lo <= '0;
      live_hi <= '0;
    end else if (!en || frame_end) begin
      live_lo <= pend_lo;
      live_hi <= pend_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (addr == ADR_KEY) begin
        rdata[0] <= unlocked;
      end else if (addr == ADR_CFG) begin
        rdata[CFG_EN]   <= en;
        rdata[CFG_HPOL] <= hpol;
        rdata[CFG_VPOL] <= vpol;
      end else begin
        for (int i = 0; i < NTIM; i++) begin
          if (addr == AW'(i + 2)) begin
            rdata[CW-1:0]      <= pend_lo[i];
            rdata[HI_LSB +: CW] <= pend_hi[i];
          end
        end
      end
    end
  end

  // R1: a write while locked leaves every protected value untouched
  assert_locked_write_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (wr && addr != ADR_KEY && !unlocked) |=>
      ($stable(pend_lo) && $stable(pend_hi) && $stable({en, hpol, vpol})));

  // R10: the live timing only moves at a frame boundary while running
  assert_live_frame_only_R10: assert property (@(posedge clk) disable iff (rst)
    (en && !frame_end) |=> ($stable(live_lo) && $stable(live_hi)));
endmodule

// File: rtl/rtg_axis_cnt.sv
module rtg_axis_cnt #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] last,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  assign wrap = run && step && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end
  end

  // R5: a count never runs past the programmed total
  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);

  // R5: without a step the count holds
  assert_cnt_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (run && !step) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/rtg_window.sv
module rtg_window #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] pos,
  input  logic [CW-1:0] act_m1,
  input  logic [CW-1:0] blk_lo,
  input  logic [CW-1:0] blk_hi,
  input  logic [CW-1:0] syn_lo,
  input  logic [CW-1:0] syn_hi,
  output logic          in_act,
  output logic          in_blk,
  output logic          in_syn
);
  // stored values are position minus one, so start/end compare shifts by one
  assign in_act = (pos <= act_m1);
  assign in_blk = (pos > blk_lo) && (pos <= blk_hi);
  assign in_syn = (pos > syn_lo) && (pos <= syn_hi);
endmodule

// File: rtl/raster_timing_top.sv
module raster_timing_top
  import rtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          active_o,
  output logic          blank_o,
  output logic          hsync_o,
  output logic          vsync_o
);
  localparam int NAX = 2;

  logic                    en, hpol, vpol;
  logic [NTIM-1:0][CW-1:0] live_lo, live_hi;
  logic [NAX-1:0][CW-1:0]  cnt;
  logic [NAX-1:0]          step, wrap, in_act, in_blk, in_syn;

  rtg_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .frame_end(wrap[1]), .rdata(reg_rdata), .en(en), .hpol(hpol), .vpol(vpol),
    .live_lo(live_lo), .live_hi(live_hi)
  );

  assign step[0] = 1'b1;
  assign step[1] = wrap[0];

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    rtg_axis_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .run(en), .step(step[a]),
      .last(live_hi[a*WPA + W_ACT]), .cnt(cnt[a]), .wrap(wrap[a])
    );
    rtg_window #(.CW(CW)) u_win (
      .pos(cnt[a]),
      .act_m1(live_lo[a*WPA + W_ACT]),
      .blk_lo(live_lo[a*WPA + W_BLK]), .blk_hi(live_hi[a*WPA + W_BLK]),
      .syn_lo(live_lo[a*WPA + W_SYN]), .syn_hi(live_hi[a*WPA + W_SYN]),
      .in_act(in_act[a]), .in_blk(in_blk[a]), .in_syn(in_syn[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_x    <= '0;
      pix_y    <= '0;
      active_o <= 1'b0;
      blank_o  <= 1'b1;
      hsync_o  <= 1'b0;
      vsync_o  <= 1'b0;
    end else begin
      pix_x    <= cnt[0];
      pix_y    <= cnt[1];
      active_o <= en && in_act[0] && in_act[1];
      blank_o  <= !en || in_blk[0] || in_blk[1];
      hsync_o  <= (en && in_syn[0]) ^ hpol;
      vsync_o  <= (en && in_syn[1]) ^ vpol;
    end
  end

  // R3: a cleared enable forces blanking and no active pixel on the next edge
  assert_idle_blank_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> (blank_o && !active_o));

  // R5: the line count only moves when the pixel count wraps
  assert_line_step_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap[0]) |=> $stable(cnt[1]));
endmodule

// File: tb/raster_timing_top_tb.sv
module raster_timing_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [CW-1:0] pix_x, pix_y;
  logic          active_o, blank_o, hsync_o, vsync_o;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // mode in true positions: active, total, blank start/end, sync start/end
  int ha, ht, hbs, hbe, hss, hse;
  int va, vt, vbs, vbe, vss, vse;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_top #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_x(pix_x), .pix_y(pix_y),
    .active_o(active_o), .blank_o(blank_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    chk(reg_rdata == exp, req, "readback", reg_rdata, exp);
  endtask

  function automatic logic [31:0] pack(input int lo, input int hi);
    return (32'(hi - 1) << 16) | 32'(lo - 1);
  endfunction

  task automatic program_mode();
    wr_reg(3'd2, pack(ha, ht));
    wr_reg(3'd3, pack(hbs, hbe));
    wr_reg(3'd4, pack(hss, hse));
    wr_reg(3'd5, pack(va, vt));
    wr_reg(3'd6, pack(vbs, vbe));
    wr_reg(3'd7, pack(vss, vse));
  endtask

  task automatic set_base_mode();
    ha = 8; ht = 16; hbs = 8; hbe = 16; hss = 10; hse = 13;
    va = 4; vt = 8;  vbs = 4; vbe = 8;  vss = 5;  vse = 7;
  endtask

  // compare outputs against the position model for one pixel
  task automatic chk_pixel(input int x, input int y, input bit hp, input bit vp,
                           input int s0, input int s1, input string req);
    bit e_act, e_blk, e_hs, e_vs;
    e_act = (x < ha) && (y < va);
    e_blk = (x >= hbs && x < hbe) || (y >= vbs && y < vbe);
    e_hs  = ((x >= s0) && (x < s1)) ^ hp;
    e_vs  = ((y >= vss) && (y < vse)) ^ vp;
    chk(pix_x == CW'(x) && pix_y == CW'(y) && active_o == e_act &&
        blank_o == e_blk && hsync_o == e_hs && vsync_o == e_vs, req,
        $sformatf("pixel (%0d,%0d) {x,y,act,blk,hs,vs}", x, y),
        {8'(pix_x), 8'(pix_y), 4'(active_o), 4'(blank_o), 4'(hsync_o), 4'(vsync_o)},
        {8'(x), 8'(y), 4'(e_act), 4'(e_blk), 4'(e_hs), 4'(e_vs)});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(blank_o == 1'b1 && active_o == 1'b0, "R3", "reset blank/active",
        {blank_o, active_o}, 2'b10);
    chk(pix_x == 0 && pix_y == 0, "R3", "reset position", {pix_x, pix_y}, 0);
    rd_chk(3'd0, 32'd0, "R1");
    rd_chk(3'd1, 32'd0, "R3");
  endtask

  task automatic t_lock();
    wr_reg(3'd2, 32'h00AA_0055);
    rd_chk(3'd2, 32'd0, "R1");
    wr_reg(3'd1, 32'h1);
    rd_chk(3'd1, 32'd0, "R1");
    wr_reg(3'd0, 32'h0000_4758);
    rd_chk(3'd0, 32'd1, "R1");
    wr_reg(3'd2, 32'hF0FF_F123);
    rd_chk(3'd2, 32'h00FF_0123, "R2");
    wr_reg(3'd7, 32'h0456_0789);
    rd_chk(3'd7, 32'h0456_0789, "R2");
    wr_reg(3'd0, 32'h0000_4759);
    rd_chk(3'd0, 32'd0, "R1");
    wr_reg(3'd2, 32'h0011_0022);
    rd_chk(3'd2, 32'h00FF_0123, "R1");
    wr_reg(3'd0, 32'h0000_4758);
  endtask

  // enable then walk n pixels; optional mid-run sync rewrite at pixel 20
  task automatic run_mode(input bit hp, input bit vp, input int n, input bit midw,
                          input string req);
    wr_reg(3'd1, {29'd0, vp, hp, 1'b1});
    for (int i = 0; i < n; i++) begin
      int fr, pos;
      @(negedge clk);
      fr  = i / (ht * vt);
      pos = i % (ht * vt);
      if (midw && fr >= 1)
        chk_pixel(pos % ht, pos / ht, hp, vp, 11, 15, "R10");
      else
        chk_pixel(pos % ht, pos / ht, hp, vp, hss, hse, req);
      if (midw && i == 20) begin
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = pack(11, 15);
      end else if (midw && i == 21) begin
        reg_wr = 1'b0;
      end
    end
  endtask

  task automatic t_frames();
    set_base_mode();
    program_mode();
    run_mode(1'b0, 1'b0, 2 * 16 * 8, 1'b0, "R4 R5 R6 R7 R8");
  endtask

  task automatic t_disable(input bit hp, input bit vp);
    wr_reg(3'd1, {29'd0, vp, hp, 1'b0});
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i >= 1)
        chk(pix_x == 0 && pix_y == 0 && blank_o && !active_o &&
            hsync_o == hp && vsync_o == vp, "R3", "idle outputs",
            {pix_x, pix_y, blank_o, active_o, hsync_o, vsync_o},
            {24'd0, 1'b1, 1'b0, hp, vp});
    end
  endtask

  task automatic t_polarity();
    wr_reg(3'd1, 32'h6);
    run_mode(1'b1, 1'b1, 16 * 8, 1'b0, "R9");
    t_disable(1'b1, 1'b1);
  endtask

  task automatic t_other_mode();
    ha = 5; ht = 12; hbs = 5; hbe = 11; hss = 6; hse = 8;
    va = 3; vt = 6;  vbs = 3; vbe = 6;  vss = 4; vse = 5;
    wr_reg(3'd1, 32'h0);
    program_mode();
    run_mode(1'b0, 1'b1, 12 * 6 + 15, 1'b0, "R6 R7 R8");
  endtask

  task automatic t_midframe();
    set_base_mode();
    wr_reg(3'd1, 32'h0);
    program_mode();
    run_mode(1'b0, 1'b0, 2 * 16 * 8, 1'b1, "R10");
    rd_chk(3'd4, pack(11, 15), "R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lock();
    t_frames();
    t_disable(1'b0, 1'b0);
    t_polarity();
    t_other_mode();
    t_midframe();
    t_disable(1'b0, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule